// File: doc/BRIEF.md
# Buffered PWM Reload Controller

This block is a multi-channel pulse-width modulator for motor and power stages. Software sets up the period, the clock prescale and one duty value per channel through an 8-bit register bus. Those values go into shadow (buffer) registers. They reach the counter and the comparators only at the start of a reload cycle, and only when software has armed the transfer with a load-enable bit. The load-enable bit clears itself once the transfer is done, so a fresh set of values is always applied whole and on a period boundary.

The counter counts either up and wraps (edge-aligned) or up and then back down (centre-aligned). A reload cycle spans a programmable number of counter periods. Each reload cycle raises a sticky reload flag, which drives an interrupt request through an enable bit. The flag is cleared by reading the control register while the flag is set and then writing 0 to it. If a new reload starts between those two steps, the clear is cancelled. When the module is disabled, the counter stops and the pins are released (tri-state). A pin-hold bit keeps them driven low instead.

Register map (addr): 0 = control, 1 = configuration, 2 = modulus buffer, 3 + i = duty buffer of channel i.

Top module: `pwm_reload_ctrl`

## Requirements
- R1: After reset all control bits, the reload flag, the buffers and the active values are 0. A read of the control register returns 0, `irq` is 0 and every `pwmOutEn` and `pwmOut` bit is 0.
- R2: Edge-aligned mode (configuration bit 5 = 0) steps the phase 0..M-1, where M is the active modulus and 0 counts as 1. A channel is high while phase < duty. One period lasts ratio*M clock cycles and the channel is high for ratio*duty of them.
- R3: Centre-aligned mode (configuration bit 5 = 1) compares the sequence 0..M-1 followed by M-1..0. One period lasts 2*ratio*M cycles and the channel is high for 2*ratio*duty of them.
- R4: A duty of 0 keeps a channel low for the whole period. A duty equal to or greater than M keeps it high for the whole period.
- R5: Configuration bits [1:0] = s select a prescale ratio of 2^s (1, 2, 4 or 8) counter clocks per phase step. This field is buffered like the modulus.
- R6: Writes to the modulus, prescale and duty buffers do not change the output until control bit 1 (load-enable) is 1 at the start of a reload cycle. At that start the buffers are copied to the active registers and load-enable returns to 0 by itself.
- R7: Writing 0 to load-enable before the next reload cycle begins cancels the pending transfer. The active values are then kept.
- R8: A reload cycle begins when control bit 0 (enable) goes from 0 to 1, and after that every N counter periods, where N = configuration bits [4:2] + 1. The reload flag (control bit 7) is set at every reload start, whether or not load-enable is set.
- R9: The reload flag clears only when a control-register read that sees the flag at 1 is followed by a control write with bit 7 = 0. A write without that read, or one preceded by a new reload since the read, leaves the flag at 1. A reload in the same cycle as the clearing write also wins.
- R10: `irq` is high exactly while the reload flag and control bit 2 (interrupt enable) are both 1. Clearing the flag removes a pending request.
- R11: With enable at 0 the counter stops, no reload occurs, `pwmOut` is 0 and `pwmOutEn` is 0. If control bit 3 (pin hold) is 1, `pwmOutEn` is 1 on every channel and the pins are driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register address |
| wrEn | input | 1 | Register write strobe |
| wrData | input | DATA_W | Write data |
| rdEn | input | 1 | Register read strobe (arms the flag clear) |
| rdData | output | DATA_W | Read data, combinational from `addr` |
| pwmOut | output | CH_COUNT | PWM level per channel |
| pwmOutEn | output | CH_COUNT | Pad drive enable per channel; 0 means high-impedance |
| irq | output | 1 | Reload interrupt request |

## Verification
The generator is run with a table of configurations that covers both counting modes, all four prescale ratios and duties of 0, inside the range, equal to the modulus and above it. Counting high cycles over two whole periods separates a wrong period length from a wrong comparison. Directed sequences write new buffers with load-enable clear, set and then withdrawn, to show that values move only on a reload with load-enable set. The flag tests try a bare write, a read followed by a reload and then a write, and a proper read-then-write, and they time successive reload flags to confirm the period multiple. Disabling with and without pin hold shows the tri-state and driven-low states and that reloads stop.

// File: rtl/pwm_reload_pkg.sv
package pwm_reload_pkg;
  // register addresses
  localparam int ADR_CTRL  = 0;
  localparam int ADR_CFG   = 1;
  localparam int ADR_MOD   = 2;
  localparam int ADR_DUTY0 = 3;
  // control register bit positions
  localparam int B_RUN  = 0;
  localparam int B_LOAD = 1;
  localparam int B_IRQ  = 2;
  localparam int B_HOLD = 3;
  localparam int B_FLAG = 7;
  // configuration field widths
  localparam int PRE_W = 2;
  localparam int RLD_W = 3;
  localparam int CFG_W = PRE_W + RLD_W + 1;

  typedef struct packed {
    logic runEn;     // generator may count
    logic startStb;  // enable just rose: restart counters
    logic loadStb;   // copy buffers into active registers
  } dpCmd_t;
endpackage

// File: rtl/pwm_reload_ctrl_regs.sv
module pwm_reload_ctrl_regs
  import pwm_reload_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CH_COUNT = 2,
  parameter int ADDR_W   = 3
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [ADDR_W-1:0]                addr,
  input  logic                             wrEn,
  input  logic [DATA_W-1:0]                wrData,
  input  logic                             rdEn,
  output logic [DATA_W-1:0]                rdData,
  input  logic                             cycleEnd,
  output dpCmd_t                           cmd,
  output logic [DATA_W-1:0]                bufMod,
  output logic [PRE_W-1:0]                 bufPre,
  output logic [CH_COUNT-1:0][DATA_W-1:0]  bufDuty,
  output logic [RLD_W-1:0]                 rldField,
  output logic                             centerMode,
  output logic                             runEn,
  output logic                             loadOk,
  output logic                             irqEn,
  output logic                             pinHold,
  output logic                             reloadFlag,
  output logic                             reloadEvt,
  output logic                             irq
);
  logic             runEnD;
  logic             clrArmed;
  logic [CFG_W-1:0] cfgReg;
  logic             startStb;
  logic             ctrlWr;
  logic             ctrlRd;

  assign ctrlWr    = wrEn && (int'(addr) == ADR_CTRL);
  assign ctrlRd    = rdEn && (int'(addr) == ADR_CTRL);
  assign startStb  = runEn && !runEnD;
  assign reloadEvt = startStb || cycleEnd;

  assign bufPre     = cfgReg[PRE_W-1:0];
  assign rldField   = cfgReg[PRE_W +: RLD_W];
  assign centerMode = cfgReg[CFG_W-1];

  assign cmd.runEn    = runEn;
  assign cmd.startStb = startStb;
  assign cmd.loadStb  = reloadEvt && loadOk;

  assign irq = reloadFlag && irqEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runEn      <= 1'b0;
      runEnD     <= 1'b0;
      irqEn      <= 1'b0;
      pinHold    <= 1'b0;
      loadOk     <= 1'b0;
      reloadFlag <= 1'b0;
      clrArmed   <= 1'b0;
    end else begin
      runEnD <= runEn;
      if (ctrlWr) begin
        runEn   <= wrData[B_RUN];
        irqEn   <= wrData[B_IRQ];
        pinHold <= wrData[B_HOLD];
      end
      // a transfer consumes load-enable; otherwise software owns it
      if (reloadEvt && loadOk)
        loadOk <= 1'b0;
      else if (ctrlWr)
        loadOk <= wrData[B_LOAD];
      // reload beats a clearing write in the same cycle
      if (reloadEvt)
        reloadFlag <= 1'b1;
      else if (ctrlWr && !wrData[B_FLAG] && clrArmed)
        reloadFlag <= 1'b0;
      // the clear is armed by a read that saw the flag set
      if (reloadEvt || ctrlWr)
        clrArmed <= 1'b0;
      else if (ctrlRd && reloadFlag)
        clrArmed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg  <= '0;
      bufMod  <= '0;
      bufDuty <= '0;
    end else if (wrEn) begin
      if (int'(addr) == ADR_CFG) cfgReg <= wrData[CFG_W-1:0];
      if (int'(addr) == ADR_MOD) bufMod <= wrData;
      for (int i = 0; i < CH_COUNT; i++)
        if (int'(addr) == ADR_DUTY0 + i) bufDuty[i] <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    if (int'(addr) == ADR_CTRL) begin
      rdData[B_RUN]  = runEn;
      rdData[B_LOAD] = loadOk;
      rdData[B_IRQ]  = irqEn;
      rdData[B_HOLD] = pinHold;
      rdData[B_FLAG] = reloadFlag;
    end else if (int'(addr) == ADR_CFG) begin
      rdData[CFG_W-1:0] = cfgReg;
    end else if (int'(addr) == ADR_MOD) begin
      rdData = bufMod;
    end else begin
      for (int i = 0; i < CH_COUNT; i++)
        if (int'(addr) == ADR_DUTY0 + i) rdData = bufDuty[i];
    end
  end
endmodule

// File: rtl/pwm_reload_dp.sv
module pwm_reload_dp
  import pwm_reload_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CH_COUNT = 2
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  dpCmd_t                           cmd,
  input  logic [DATA_W-1:0]                bufMod,
  input  logic [PRE_W-1:0]                 bufPre,
  input  logic [CH_COUNT-1:0][DATA_W-1:0]  bufDuty,
  input  logic [RLD_W-1:0]                 rldField,
  input  logic                             centerMode,
  output logic                             cycleEnd,
  output logic [DATA_W-1:0]                modAct,
  output logic [CH_COUNT-1:0]              pwmRaw
);
  localparam int PRE_CNT_W = (2 ** PRE_W) - 1;  // enough for the largest ratio
  localparam int PH_W      = DATA_W + 1;        // centre mode doubles the range

  logic [PRE_W-1:0]                 preAct;
  logic [CH_COUNT-1:0][DATA_W-1:0]  dutyAct;
  logic [PRE_CNT_W-1:0]             preCnt;
  logic [PRE_CNT_W-1:0]             ratioM1;
  logic [PH_W-1:0]                  phase;
  logic [PH_W-1:0]                  effMod;
  logic [PH_W-1:0]                  lastPhase;
  logic [PH_W-1:0]                  cmpVal;
  logic [RLD_W-1:0]                 perCnt;
  logic                             tick;
  logic                             periodEnd;

  assign effMod    = (modAct == '0) ? PH_W'(1) : {1'b0, modAct};
  assign lastPhase = centerMode ? ((effMod << 1) - PH_W'(1)) : (effMod - PH_W'(1));
  assign ratioM1   = PRE_CNT_W'((1 << preAct) - 1);
  assign tick      = cmd.runEn && !cmd.startStb && (preCnt >= ratioM1);
  assign periodEnd = tick && (phase >= lastPhase);
  assign cycleEnd  = periodEnd && (perCnt >= rldField);
  // centre mode folds the second half back down
  assign cmpVal    = (centerMode && (phase >= effMod)) ? (lastPhase - phase) : phase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      phase  <= '0;
      perCnt <= '0;
    end else if (!cmd.runEn || cmd.startStb) begin
      preCnt <= '0;
      phase  <= '0;
      perCnt <= '0;
    end else if (tick) begin
      preCnt <= '0;
      if (periodEnd) begin
        phase  <= '0;
        perCnt <= cycleEnd ? '0 : perCnt + RLD_W'(1);
      end else begin
        phase <= phase + PH_W'(1);
      end
    end else begin
      preCnt <= preCnt + PRE_CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modAct  <= '0;
      preAct  <= '0;
      dutyAct <= '0;
    end else if (cmd.loadStb) begin
      modAct  <= bufMod;
      preAct  <= bufPre;
      dutyAct <= bufDuty;
    end
  end

  for (genvar g = 0; g < CH_COUNT; g++) begin : g_cmp
    logic dutyZero;
    logic dutyFull;
    assign dutyZero  = (dutyAct[g] == '0);
    assign dutyFull  = ({1'b0, dutyAct[g]} >= effMod);
    assign pwmRaw[g] = cmd.runEn && !dutyZero && (dutyFull || (cmpVal < {1'b0, dutyAct[g]}));
  end
endmodule

// File: rtl/pwm_reload_ctrl.sv
module pwm_reload_ctrl
  import pwm_reload_pkg::*;
#(
  parameter  int DATA_W   = 8,
  parameter  int CH_COUNT = 2,
  localparam int ADDR_W   = $clog2(ADR_DUTY0 + CH_COUNT)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wrEn,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 rdEn,
  output logic [DATA_W-1:0]    rdData,
  output logic [CH_COUNT-1:0]  pwmOut,
  output logic [CH_COUNT-1:0]  pwmOutEn,
  output logic                 irq
);
  dpCmd_t                           cmd;
  logic [DATA_W-1:0]                bufMod;
  logic [PRE_W-1:0]                 bufPre;
  logic [CH_COUNT-1:0][DATA_W-1:0]  bufDuty;
  logic [RLD_W-1:0]                 rldField;
  logic                             centerMode;
  logic                             cycleEnd;
  logic [DATA_W-1:0]                modAct;
  logic                             runEn;
  logic                             loadOk;
  logic                             irqEn;
  logic                             pinHold;
  logic                             reloadFlag;
  logic                             reloadEvt;

  pwm_reload_ctrl_regs #(.DATA_W(DATA_W), .CH_COUNT(CH_COUNT), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .cycleEnd(cycleEnd), .cmd(cmd),
    .bufMod(bufMod), .bufPre(bufPre), .bufDuty(bufDuty), .rldField(rldField),
    .centerMode(centerMode), .runEn(runEn), .loadOk(loadOk), .irqEn(irqEn),
    .pinHold(pinHold), .reloadFlag(reloadFlag), .reloadEvt(reloadEvt), .irq(irq)
  );

  pwm_reload_dp #(.DATA_W(DATA_W), .CH_COUNT(CH_COUNT)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .bufMod(bufMod), .bufPre(bufPre),
    .bufDuty(bufDuty), .rldField(rldField), .centerMode(centerMode),
    .cycleEnd(cycleEnd), .modAct(modAct), .pwmRaw(pwmOut)
  );

  assign pwmOutEn = {CH_COUNT{runEn || pinHold}};
endmodule

// File: rtl/pwm_reload_ctrl_chk.sv
module pwm_reload_ctrl_chk #(
  parameter int DATA_W   = 8,
  parameter int CH_COUNT = 2,
  parameter int ADDR_W   = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   addr,
  input logic                wrEn,
  input logic                runEn,
  input logic                loadOk,
  input logic                irqEn,
  input logic                reloadFlag,
  input logic                reloadEvt,
  input logic [DATA_W-1:0]   modAct,
  input logic [CH_COUNT-1:0] pwmOut,
  input logic                irq
);
  assert_flag_on_reload_R8: assert property (@(posedge clk) disable iff (!rstN)
    reloadEvt |=> reloadFlag);

  assert_load_selfclear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reloadEvt && loadOk) |=> !loadOk);

  assert_active_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(reloadEvt && loadOk) |=> $stable(modAct));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reloadFlag && !(wrEn && addr == '0)) |=> reloadFlag);

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |-> !irq);

  assert_idle_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> (pwmOut == '0));

  assert_no_reload_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> !reloadEvt);
endmodule

bind pwm_reload_ctrl pwm_reload_ctrl_chk #(.DATA_W(DATA_W), .CH_COUNT(CH_COUNT), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .runEn(runEn), .loadOk(loadOk),
  .irqEn(irqEn), .reloadFlag(reloadFlag), .reloadEvt(reloadEvt), .modAct(modAct),
  .pwmOut(pwmOut), .irq(irq)
);

// File: tb/pwm_reload_ctrl_tb.sv
module pwm_reload_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CH = 2;

  typedef struct packed {
    logic       center;
    logic [1:0] pre;
    logic [7:0] modv;
    logic [7:0] d0;
    logic [7:0] d1;
    logic [15:0] per;
    logic [15:0] h0;
    logic [15:0] h1;
  } vec_t;

  // expected per period: per = ratio*M (edge) or 2*ratio*M (centre)
  localparam vec_t VECS [5] = '{
    '{1'b0, 2'd0, 8'd10, 8'd3, 8'd0, 16'd10, 16'd3,  16'd0},   // R2 R4 duty 0
    '{1'b0, 2'd1, 8'd6,  8'd6, 8'd9, 16'd12, 16'd12, 16'd12},  // R4 duty>=M, R5 x2
    '{1'b1, 2'd0, 8'd5,  8'd2, 8'd4, 16'd10, 16'd4,  16'd8},   // R3
    '{1'b1, 2'd2, 8'd4,  8'd1, 8'd3, 16'd32, 16'd8,  16'd24},  // R3 R5 x4
    '{1'b0, 2'd3, 8'd3,  8'd1, 8'd2, 16'd24, 16'd8,  16'd16}   // R2 R5 x8
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [2:0]    addr = '0;
  logic          wrEn = 1'b0;
  logic [7:0]    wrData = '0;
  logic          rdEn = 1'b0;
  logic [7:0]    rdData;
  logic [CH-1:0] pwmOut;
  logic [CH-1:0] pwmOutEn;
  logic          irq;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;

  pwm_reload_ctrl #(.DATA_W(8), .CH_COUNT(CH)) u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .pwmOut(pwmOut), .pwmOutEn(pwmOutEn), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    addr = 3'(a); wrData = 8'(d); wrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    addr = 3'(a); rdEn = 1'b1;
    #1 d = rdData;
    @(posedge clk); @(negedge clk);
    rdEn = 1'b0;
  endtask

  // program, then enable with load-enable set (start of a reload cycle)
  task automatic setup(input logic cen, input int pre, input int rld,
                       input int m, input int d0, input int d1);
    wr(0, 8'h00);
    wr(1, {2'b00, cen, 3'(rld), 2'(pre)});
    wr(2, m);
    wr(3, d0);
    wr(4, d1);
    wr(0, 8'h03);
  endtask

  task automatic measure(input int cycles, output int c0, output int c1);
    c0 = 0; c1 = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pwmOut[0]) c0++;
      if (pwmOut[1]) c1++;
    end
  endtask

  task automatic waitIrq(output int t);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (irq) break;
    end
    t = cyc;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int c0, c1, t0, t1;

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pwmOutEn", int'(pwmOutEn), 0);
    check("R1 pwmOut", int'(pwmOut), 0);
    check("R1 irq", int'(irq), 0);
    rstN = 1'b1;
    rd(0, r); check("R1 ctrl", int'(r), 0);
    rd(2, r); check("R1 modulus buffer", int'(r), 0);

    // table of configurations
    foreach (VECS[k]) begin
      setup(VECS[k].center, int'(VECS[k].pre), 0, int'(VECS[k].modv),
            int'(VECS[k].d0), int'(VECS[k].d1));
      measure(2 * int'(VECS[k].per), c0, c1);
      check($sformatf("R2/R3/R4/R5 vec%0d ch0 high", k), c0, 2 * int'(VECS[k].h0));
      check($sformatf("R2/R3/R4/R5 vec%0d ch1 high", k), c1, 2 * int'(VECS[k].h1));
      check($sformatf("R11 vec%0d drive", k), int'(pwmOutEn), 3);
      rd(0, r);
      check($sformatf("R8 vec%0d flag after start", k), int'(r[7]), 1);
      check($sformatf("R6 vec%0d load-enable cleared", k), int'(r[1]), 0);
    end

    // R6 buffered duty has no effect without load-enable
    setup(1'b0, 0, 0, 10, 3, 0);
    wr(3, 7);
    measure(40, c0, c1);
    check("R6 held duty", c0, 12);
    wr(0, 8'h03);
    r = 8'h02;
    for (int i = 0; i < 30 && r[1]; i++) rd(0, r);
    check("R6 load-enable self-clear", int'(r[1]), 0);
    measure(20, c0, c1);
    check("R6 transferred duty", c0, 14);

    // R7 withdrawn load-enable
    setup(1'b0, 0, 7, 10, 3, 0);
    wr(3, 7);
    wr(0, 8'h03);
    wr(0, 8'h01);
    repeat (100) @(negedge clk);
    rd(0, r);
    check("R7 load-enable stays 0", int'(r[1]), 0);
    measure(20, c0, c1);
    check("R7 old duty kept", c0, 6);

    // R8 reload interval N*period, N=3, M=4
    setup(1'b0, 0, 2, 4, 1, 0);
    wr(0, 8'h05);
    rd(0, r); wr(0, 8'h05);
    check("R10 irq cleared with flag", int'(irq), 0);
    waitIrq(t0);
    rd(0, r); wr(0, 8'h05);
    waitIrq(t1);
    check("R8 reload interval", t1 - t0, 12);

    // R9 write without read has no effect
    wr(0, 8'h05);
    rd(0, r);
    check("R9 bare write keeps flag", int'(r[7]), 1);
    // R9 reload between read and write cancels the clear
    repeat (15) @(negedge clk);
    wr(0, 8'h05);
    rd(0, r);
    check("R9 race keeps flag", int'(r[7]), 1);
    // R9 proper sequence (read above armed it)
    wr(0, 8'h05);
    check("R9 read-then-write clears irq", int'(irq), 0);
    rd(0, r);
    check("R9 flag cleared", int'(r[7]), 0);

    // R10 interrupt enable gating
    repeat (13) @(negedge clk);
    wr(0, 8'h01);
    rd(0, r);
    check("R10 flag pending", int'(r[7]), 1);
    check("R10 irq inhibited", int'(irq), 0);

    // R11 disable: tri-state, then pin hold
    wr(0, 8'h00);
    check("R11 released", int'(pwmOutEn), 0);
    check("R11 output low", int'(pwmOut), 0);
    rd(0, r);
    wr(0, 8'h08);
    check("R11 hold drives", int'(pwmOutEn), 3);
    check("R11 hold low", int'(pwmOut), 0);
    repeat (30) @(negedge clk);
    rd(0, r);
    check("R11 no reload while disabled", int'(r[7]), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule